// File: doc/BRIEF.md
# Programmable Chip-Select Generator

This block watches the address, direction and address-space code of each bus cycle on a 24-bit bus. It raises one select line for every channel whose programmed window and qualifiers fit the cycle. Each channel holds three things: a base address, a block-size code that sets how far the window reaches above the base, and an option word. The option word names the address spaces and directions the channel answers, how its select is timed, its port width and how the cycle is acknowledged.

The block can finish a bus cycle by itself. A single cycle counter is shared by all channels. It raises a byte-wide or word-wide data acknowledge after the programmed number of wait states, or after a fast two-clock termination. A channel that is set to answer interrupt-acknowledge cycles can instead raise an autovector acknowledge. Configuration is written through a simple one-cycle write port that carries a channel index, a register kind and a data word.

Top module: `csel_unit`

## Requirements
- R1: After reset every channel is disabled: no select and no acknowledge is raised for any cycle until a channel is configured.
- R2: The base register holds address bits 23:11, written from cfg_data[12:0] with cfg_kind 0. The size code is written from cfg_data[3:0] with cfg_kind 1. Code s from 0 to 9 gives a block of 2^(11+s) bytes, from 2 Kbytes to 1 Mbyte, and codes 10 to 15 act as 9. A non-interrupt channel matches when addr[23:11+s] equals the base bits at those positions.
- R3: The option word is written from cfg_data[13:0] with cfg_kind 2. A channel whose option word is all zeros, or whose direction field bits 9:8 are 00, never matches.
- R4: Direction field bits 9:8: 01 matches reads only (rw=1), 10 matches writes only (rw=0), 11 matches both.
- R5: Space field bits 7:6: 01 matches fc 001 or 010, 10 matches fc 101 or 110, 11 matches all four of these. 00 matches only interrupt-acknowledge cycles (fc 111). Such a channel ignores the base compare and matches when its level field bits 3:1 is 000 or equals addr[3:1].
- R6: Strobe bit 5: when 0 the select follows bus_active; when 1 the select is also gated by ds. Gating by ds does not change the acknowledge.
- R7: Acknowledge field bits 13:10: a code W from 0 to 13 raises the internal acknowledge once W+2 rising clock edges have passed within the cycle. Code 1110 raises it after one edge, so the access completes in two clocks. Code 1111 leaves the acknowledge to external logic and raises nothing.
- R8: Port-size bit 4: 1 returns the acknowledge on ack16, 0 on ack8. At most one of ack8, ack16 and avec is high at any time.
- R9: An interrupt-acknowledge channel with autovector bit 0 set raises avec instead of ack8/ack16, with the same timing. Without that bit it raises the data acknowledge.
- R10: When several channels match, the lowest-numbered matching channel whose acknowledge code is not 1111 sets the timing, width and kind of the internal acknowledge. Each matching channel still raises its own select.
- R11: Once raised, the acknowledge stays high until bus_active falls. While bus_active is low all selects and acknowledges are low.
- R12: A configuration write with cfg_kind 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_ch | input | 2 | Channel index of the write |
| cfg_kind | input | 2 | 0 base, 1 size code, 2 option word, 3 no effect |
| cfg_data | input | 14 | Write data |
| bus_active | input | 1 | High for the whole duration of a bus cycle |
| addr | input | 24 | Cycle address; bits 3:1 carry the level in interrupt-acknowledge cycles |
| rw | input | 1 | 1 read, 0 write |
| fc | input | 3 | Address-space code of the cycle |
| ds | input | 1 | Data strobe, used by strobe-timed channels |
| cs | output | 4 | Active-high select per channel |
| ack8 | output | 1 | Internal acknowledge, byte-wide port |
| ack16 | output | 1 | Internal acknowledge, word-wide port |
| avec | output | 1 | Autovector acknowledge |

## Verification
The hardest case to reach is a set of overlapping channels whose acknowledge codes differ. In that case the winner of the internal acknowledge is not simply the first channel that matches, and the loser's wait count must have no effect. The stimulus maps two channels onto one window. It then changes only the lower channel's code, first to a short wait and then to external. Each cycle measures the edge on which the acknowledge appears and which line carries it, so any change in priority shows up as a different count or width. The longest wait code is run the same way to reach the top of the shared counter.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // option word layout, msb first
  typedef struct packed {
    logic [3:0] ack;     // wait code, fast code or external
    logic [1:0] rw;      // [0] reads allowed, [1] writes allowed
    logic [1:0] space;   // 00 interrupt acknowledge, [0] user, [1] supervisor
    logic       strobe;  // gate select with data strobe
    logic       wide;    // 1 word port, 0 byte port
    logic [2:0] ipl;     // interrupt level, 000 any
    logic       av;      // autovector on interrupt acknowledge
  } opt_t;

  localparam int OPT_W = $bits(opt_t);
  localparam int SZW   = 4;

  localparam logic [3:0] ACK_FAST = 4'hE;
  localparam logic [3:0] ACK_EXT  = 4'hF;
  localparam logic [1:0] SP_IACK  = 2'b00;

  localparam logic [1:0] KIND_BASE = 2'd0;
  localparam logic [1:0] KIND_SIZE = 2'd1;
  localparam logic [1:0] KIND_OPT  = 2'd2;

  localparam logic [2:0] FC_UDATA = 3'b001;
  localparam logic [2:0] FC_UPROG = 3'b010;
  localparam logic [2:0] FC_SDATA = 3'b101;
  localparam logic [2:0] FC_SPROG = 3'b110;
  localparam logic [2:0] FC_IACK  = 3'b111;

endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int BASEW = 13,
  localparam int CHW  = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CHW-1:0]   cfg_ch,
  input  logic [1:0]       cfg_kind,
  input  logic [OPT_W-1:0] cfg_data,
  output logic [BASEW-1:0] base_q [NCH],
  output logic [SZW-1:0]   size_q [NCH],
  output opt_t             opt_q  [NCH]
);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic ch_hit, en_base, en_size, en_opt;

    always_comb begin
      ch_hit  = cfg_we && (cfg_ch == CHW'(g));
      en_base = ch_hit && (cfg_kind == KIND_BASE);
      en_size = ch_hit && (cfg_kind == KIND_SIZE);
      en_opt  = ch_hit && (cfg_kind == KIND_OPT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        size_q[g] <= '0;
        opt_q[g]  <= '0;
      end else begin
        if (en_base) base_q[g] <= cfg_data[BASEW-1:0];
        if (en_size) size_q[g] <= cfg_data[SZW-1:0];
        if (en_opt)  opt_q[g]  <= opt_t'(cfg_data);
      end
    end
  end

endmodule

// File: rtl/csel_match.sv
module csel_match
  import csel_pkg::*;
#(
  parameter int BASEW = 13,
  parameter int NSIZE = 10
) (
  input  logic [BASEW-1:0] addr_hi,
  input  logic [2:0]       lvl,
  input  logic             rw,
  input  logic [2:0]       fc,
  input  logic [BASEW-1:0] base,
  input  logic [SZW-1:0]   size,
  input  opt_t             opt,
  output logic             hit
);

  localparam logic [SZW-1:0] SZ_MAX = SZW'(NSIZE - 1);

  logic [SZW-1:0] eff_sz;
  logic           addr_ok, rw_ok, sp_ok, lvl_ok, is_iack, is_user, is_sup, enabled;

  always_comb begin
    eff_sz  = (size > SZ_MAX) ? SZ_MAX : size;
    addr_ok = 1'b1;
    for (int i = 0; i < BASEW; i++) begin
      if (i >= int'(eff_sz) && addr_hi[i] != base[i]) addr_ok = 1'b0;
    end
    is_iack = (fc == FC_IACK);
    is_user = (fc == FC_UDATA) || (fc == FC_UPROG);
    is_sup  = (fc == FC_SDATA) || (fc == FC_SPROG);
    enabled = (opt != '0);
    rw_ok   = rw ? opt.rw[0] : opt.rw[1];
    sp_ok   = (opt.space[0] && is_user) || (opt.space[1] && is_sup);
    lvl_ok  = (opt.ipl == 3'b000) || (opt.ipl == lvl);
    if (opt.space == SP_IACK) hit = enabled && rw_ok && is_iack && lvl_ok;
    else                      hit = enabled && rw_ok && sp_ok && addr_ok;
  end

endmodule

// File: rtl/csel_ack.sv
module csel_ack
  import csel_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CNTW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_active,
  input  logic [NCH-1:0] hit,
  input  opt_t           opt [NCH],
  output logic           ack8,
  output logic           ack16,
  output logic           avec
);

  localparam logic [CNTW-1:0] CNT_MAX = '1;

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [CNTW:0]   tgt;
  opt_t            win;
  logic            found, use_av, done;

  // lowest-numbered internally acknowledged channel wins
  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (hit[i] && opt[i].ack != ACK_EXT) begin
        found = 1'b1;
        win   = opt[i];
      end
    end
    tgt    = (win.ack == ACK_FAST) ? (CNTW+1)'(1) : (CNTW+1)'(win.ack) + (CNTW+1)'(2);
    use_av = win.av && (win.space == SP_IACK);
    done   = bus_active && found && ({1'b0, cnt_q} >= tgt);
    ack8   = done && !use_av && !win.wide;
    ack16  = done && !use_av && win.wide;
    avec   = done && use_av;
  end

  always_comb begin
    if (!bus_active)           cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int ADDR_W   = 24,
  parameter int MIN_LOG2 = 11,
  parameter int NSIZE    = 10,
  parameter int CNTW     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [$clog2(NCH)-1:0]  cfg_ch,
  input  logic [1:0]              cfg_kind,
  input  logic [OPT_W-1:0]        cfg_data,
  input  logic                    bus_active,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    rw,
  input  logic [2:0]              fc,
  input  logic                    ds,
  output logic [NCH-1:0]          cs,
  output logic                    ack8,
  output logic                    ack16,
  output logic                    avec
);

  localparam int BASEW = ADDR_W - MIN_LOG2;

  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic [BASEW-1:0] base_q [NCH];
  logic [SZW-1:0]   size_q [NCH];
  opt_t             opt_q  [NCH];
  logic [NCH-1:0]   hit;
  logic             unused_addr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign unused_addr_bits = ^{addr[MIN_LOG2-1:4], addr[0]};

  csel_regs #(.NCH(NCH), .BASEW(BASEW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_kind(cfg_kind), .cfg_data(cfg_data),
    .base_q(base_q), .size_q(size_q), .opt_q(opt_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    csel_match #(.BASEW(BASEW), .NSIZE(NSIZE)) u_match (
      .addr_hi(addr[ADDR_W-1:MIN_LOG2]), .lvl(addr[3:1]), .rw(rw), .fc(fc),
      .base(base_q[g]), .size(size_q[g]), .opt(opt_q[g]), .hit(hit[g])
    );
    assign cs[g] = bus_active && hit[g] && (!opt_q[g].strobe || ds);
  end

  csel_ack #(.NCH(NCH), .CNTW(CNTW)) u_ack (
    .clk(clk), .rst_n(rst_int_n), .bus_active(bus_active), .hit(hit),
    .opt(opt_q), .ack8(ack8), .ack16(ack16), .avec(avec)
  );

endmodule

// File: rtl/csel_unit_chk.sv
module csel_unit_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_active,
  input logic [NCH-1:0] cs,
  input logic           ack8,
  input logic           ack16,
  input logic           avec
);

  logic any_ack;
  assign any_ack = ack8 || ack16 || avec;

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_active |-> (cs == '0 && !any_ack));

  a_r8_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack8, ack16, avec}));

  a_r7_no_first_clock_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_active) |-> !any_ack);

  a_r11_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && any_ack) |=> (any_ack || !bus_active));

endmodule

bind csel_unit csel_unit_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .cs(cs),
  .ack8(ack8), .ack16(ack16), .avec(avec)
);

// File: tb/csel_unit_tb_top.sv
`timescale 1ns/1ps
module csel_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_ch;
  logic [1:0]  cfg_kind;
  logic [13:0] cfg_data;
  logic        bus_active;
  logic [23:0] addr;
  logic        rw;
  logic [2:0]  fc;
  logic        ds;
  logic [3:0]  cs;
  logic        ack8, ack16, avec;

  int n_chk = 0;
  int n_bad = 0;

  csel_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_kind(cfg_kind), .cfg_data(cfg_data), .bus_active(bus_active),
    .addr(addr), .rw(rw), .fc(fc), .ds(ds), .cs(cs),
    .ack8(ack8), .ack16(ack16), .avec(avec)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // kind: 3'b001 ack8, 3'b010 ack16, 3'b100 avec, 0 none; k: edges before ack
  typedef struct packed {
    logic [23:0] a;
    logic        r;
    logic [2:0]  f;
    logic        d;
    logic [3:0]  ecs;
    logic [2:0]  kind;
    logic [4:0]  k;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{24'h100000, 1'b1, 3'd5, 1'b1, 4'b0001, 3'b010, 5'd2},  // R2 R7 R8 ch0 base
    '{24'h1007FF, 1'b0, 3'd1, 1'b1, 4'b0001, 3'b010, 5'd2},  // R2 ch0 top byte
    '{24'h100800, 1'b1, 3'd5, 1'b1, 4'b0000, 3'b000, 5'd0},  // R2 past 2K
    '{24'h2FFFFF, 1'b1, 3'd6, 1'b1, 4'b0010, 3'b001, 5'd1},  // R2 R7 fast 1M
    '{24'h250000, 1'b0, 3'd5, 1'b1, 4'b0000, 3'b000, 5'd0},  // R4 write on read-only
    '{24'h250000, 1'b1, 3'd2, 1'b1, 4'b0000, 3'b000, 5'd0},  // R5 user on supervisor
    '{24'h300000, 1'b0, 3'd1, 1'b1, 4'b0100, 3'b000, 5'd0},  // R6 R7 external ack
    '{24'h303FFF, 1'b0, 3'd2, 1'b0, 4'b0000, 3'b000, 5'd0},  // R6 strobe low
    '{24'h304000, 1'b0, 3'd1, 1'b1, 4'b0000, 3'b000, 5'd0},  // R2 past 16K
    '{24'h300010, 1'b1, 3'd1, 1'b1, 4'b0000, 3'b000, 5'd0},  // R4 read on write-only
    '{24'h00000A, 1'b1, 3'd7, 1'b1, 4'b1000, 3'b100, 5'd4},  // R5 R9 iack level 5
    '{24'h000006, 1'b1, 3'd7, 1'b1, 4'b0000, 3'b000, 5'd0},  // R5 iack level 3
    '{24'h100000, 1'b1, 3'd0, 1'b1, 4'b0000, 3'b000, 5'd0},  // R5 reserved fc 0
    '{24'h100000, 1'b1, 3'd3, 1'b1, 4'b0000, 3'b000, 5'd0},  // R5 reserved fc 3
    '{24'h0FFFFF, 1'b1, 3'd5, 1'b1, 4'b0000, 3'b000, 5'd0},  // R2 below base
    '{24'h200000, 1'b1, 3'd5, 1'b0, 4'b0010, 3'b001, 5'd1}   // R6 address-timed
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int kind, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_kind = 2'(kind); cfg_data = 14'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_cycle(input logic [23:0] a, input logic r, input logic [2:0] f,
                           input logic d, input logic [3:0] ecs, input logic [2:0] ekind,
                           input int ek, input string tag);
    int first = 0;
    logic seen = 1'b0;
    logic held = 1'b1;
    logic [2:0] got = 3'b000;
    @(negedge clk);
    addr = a; rw = r; fc = f; ds = d; bus_active = 1'b1;
    #1;
    check(cs == ecs, {tag, " select"}, cs, ecs);
    for (int k = 0; k <= 20; k++) begin
      if (k > 0) begin
        @(negedge clk);
        #1;
      end
      if ({avec, ack16, ack8} != 3'b000) begin
        if (!seen) begin
          seen = 1'b1; first = k; got = {avec, ack16, ack8};
        end
      end else if (seen) held = 1'b0;
    end
    if (ekind == 3'b000)
      check(!seen, {tag, " no internal ack"}, {got, 8'(first)}, 0);
    else begin
      check(seen && got == ekind && first == ek, {tag, " ack kind/edge"},
            {got, 8'(first)}, {ekind, 8'(ek)});
      check(held, "R11 ack held", held, 1);
    end
    @(negedge clk);
    bus_active = 1'b0; ds = 1'b0;
    #1;
    check(cs == 4'b0000 && {avec, ack16, ack8} == 3'b000, "R11 idle after cycle",
          {cs, avec, ack16, ack8}, 0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_kind = '0; cfg_data = '0;
    bus_active = 1'b0; addr = '0; rw = 1'b1; fc = 3'd5; ds = 1'b0;
    repeat (3) @(negedge clk);
    check(cs == 4'b0000 && {avec, ack16, ack8} == 3'b000, "R1 outputs in reset",
          {cs, avec, ack16, ack8}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: unconfigured channels stay silent, also for interrupt acknowledge
    run_cycle(24'h000000, 1'b1, 3'd5, 1'b1, 4'b0000, 3'b000, 0, "R1 unconfigured");
    run_cycle(24'h00000A, 1'b1, 3'd7, 1'b1, 4'b0000, 3'b000, 0, "R1 unconfigured iack");

    // channel setup: bases, sizes, options
    wr(0, 0, 24'h100000 >> 11); wr(0, 1, 0); wr(0, 2, 14'h03D0);
    wr(1, 0, 24'h200000 >> 11); wr(1, 1, 9); wr(1, 2, 14'h3980);
    wr(2, 0, 24'h300000 >> 11); wr(2, 1, 3); wr(2, 2, 14'h3E70);
    wr(3, 0, 0);                wr(3, 1, 0); wr(3, 2, 14'h0B0B);

    for (int v = 0; v < NV; v++) begin
      run_cycle(VEC[v].a, VEC[v].r, VEC[v].f, VEC[v].d, VEC[v].ecs, VEC[v].kind,
                int'(VEC[v].k), $sformatf("R2/R4/R5/R6/R7 vector %0d", v));
    end

    // R12: kind 3 writes leave channel 1 intact
    wr(1, 3, 0);
    run_cycle(24'h200000, 1'b1, 3'd5, 1'b1, 4'b0010, 3'b001, 1, "R12 kind 3 ignored");

    // R3: all-zero option, then direction field 00
    wr(0, 2, 0);
    run_cycle(24'h100000, 1'b1, 3'd5, 1'b1, 4'b0000, 3'b000, 0, "R3 zero option");
    wr(0, 2, 14'h00D0);
    run_cycle(24'h100000, 1'b1, 3'd5, 1'b1, 4'b0000, 3'b000, 0, "R3 direction 00");

    // R10: ch0 and ch2 share a window
    wr(0, 2, 14'h03D0);
    wr(2, 0, 24'h100000 >> 11); wr(2, 1, 0); wr(2, 2, 14'h17C0);
    run_cycle(24'h100000, 1'b1, 3'd5, 1'b1, 4'b0101, 3'b010, 2, "R10 lower channel wins");
    wr(0, 2, 14'h3FD0);
    run_cycle(24'h100000, 1'b0, 3'd1, 1'b1, 4'b0101, 3'b001, 7, "R10 external skipped");
    // R7: longest wait code 13
    wr(2, 2, 14'h37C0);
    run_cycle(24'h100000, 1'b1, 3'd6, 1'b1, 4'b0101, 3'b001, 15, "R7 wait 13");

    // R2: size codes above 9 act as 1 Mbyte
    wr(1, 1, 15);
    run_cycle(24'h2FFFFF, 1'b1, 3'd5, 1'b1, 4'b0010, 3'b001, 1, "R2 size clamp top");
    run_cycle(24'h300000, 1'b1, 3'd5, 1'b1, 4'b0000, 3'b000, 0, "R2 size clamp beyond");

    // R9: no autovector bit gives a data acknowledge; level 000 matches any
    wr(3, 2, 14'h0B1A);
    run_cycle(24'h00000A, 1'b1, 3'd7, 1'b1, 4'b1000, 3'b010, 4, "R9 iack without autovector");
    wr(3, 2, 14'h0B10);
    run_cycle(24'h000006, 1'b1, 3'd7, 1'b1, 4'b1000, 3'b010, 4, "R5 iack any level");

    summary();
    $finish;
  end

endmodule